// File: doc/BRIEF.md
# Interlocked Control-Endpoint Status Register

This block holds the mode and status byte of a control endpoint, together with a companion byte-count register. Both are shared between a serial interface engine and a CPU. The engine reports transaction events as single-cycle strobes and may load a new 4-bit mode or a new count. The CPU reads and writes the registers through a plain register port with a one-bit address.

Whenever the engine posts a value to one of the registers, that register is locked. CPU writes to it are then dropped until the CPU has read it, so firmware cannot overwrite an event it has not yet seen. An accepted CPU write to the mode register always clears the four event flags, whatever data is written.

The SETUP flag has an extra rule. It is pinned to 1 from the start of a SETUP data phase until the engine signals the end of the control-write data phase. The flag drives an inhibit that keeps the CPU from writing into the endpoint buffer.

Two small state machines carry the control:
- **Window machine.** It has the states `WIN_IDLE` and `WIN_HOLD`.
  - `WIN_IDLE -> WIN_HOLD` on `eng_setup_start`.
  - `WIN_HOLD -> WIN_IDLE` on `eng_ctrl_wr_end` when no new SETUP starts in that cycle.
  - Every other case keeps the current state.
- **Lock machine.** There is one per register, with the states `LK_OPEN` and `LK_HELD`.
  - `LK_OPEN -> LK_HELD` on an engine update to that register.
  - `LK_HELD -> LK_OPEN` on a CPU read of that register in a cycle with no engine update to it.
  - Every other case keeps the current state.

Top module: `ep0_status_regs`

## Requirements
- R1: After reset both registers read 0, both are unlocked, the window machine is in `WIN_IDLE` and `fifo_wr_inhibit` is 0.
- R2: Any of `eng_setup_start`, `eng_in_acked`, `eng_out_acked`, `eng_txn_acked` or `eng_mode_load` locks the mode register (address 0) at that edge. `eng_cnt_load` locks the count register (address 1). The two locks are independent.
- R3: A CPU write to a locked register is ignored. A CPU write in the same cycle as an engine update to that register is also ignored, because the engine wins.
- R4: A CPU read (`cpu_rd` with `cpu_addr`) releases that register's lock, but only in a cycle without an engine update to it. A read in the same cycle as an update returns the pre-update value and leaves the register locked.
- R5: An accepted CPU write to the mode register loads bits 3:0 from `cpu_wdata[3:0]` and clears bits 6:4. Bit 7 is also cleared outside the SETUP window. `cpu_wdata[7:4]` has no effect.
- R6: `eng_setup_start` sets bit 7 and opens the SETUP window. Inside the window bit 7 stays 1 through accepted writes. After the cycle that carries `eng_ctrl_wr_end`, an accepted write clears it again.
- R7: `eng_in_acked` sets bit 6, `eng_out_acked` sets bit 5 and `eng_txn_acked` sets bit 4. These flags are sticky until an accepted write clears them. `eng_mode_load` replaces bits 3:0 with `eng_mode_val` and leaves the flags as they are.
- R8: `fifo_wr_inhibit` is 1 exactly when bit 7 of the mode register is 1.
- R9: `eng_cnt_load` loads the count register with `eng_cnt_val`. An accepted CPU write to address 1 loads it from `cpu_wdata[CNT_W-1:0]`.
- R10: `cpu_rdata` shows the current mode register when `cpu_addr` is 0. When `cpu_addr` is 1 it shows the count register, zero-extended to 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 1 | Register select: 0 selects mode/status, 1 selects count |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe; releases the lock of the selected register |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Selected register value |
| eng_setup_start | input | 1 | Start of a SETUP data phase |
| eng_ctrl_wr_end | input | 1 | End of the control-write data phase |
| eng_in_acked | input | 1 | Host acknowledged an IN data packet |
| eng_out_acked | input | 1 | Last packet of an OUT transaction was accepted and acknowledged |
| eng_txn_acked | input | 1 | A transaction to this endpoint ended with an ACK |
| eng_mode_load | input | 1 | Load a new mode field |
| eng_mode_val | input | 4 | Mode value to load |
| eng_cnt_load | input | 1 | Load the count register |
| eng_cnt_val | input | CNT_W | Count value to load |
| fifo_wr_inhibit | output | 1 | Blocks CPU writes into the endpoint buffer |

## Verification
Every register change, lock change and window change takes effect at the rising edge that samples the strobe. Both `fifo_wr_inhibit` and the register contents seen on `cpu_rdata` are therefore due one edge after the stimulus. `cpu_rdata` itself follows `cpu_addr` combinationally, within the same cycle.

The bench drives its inputs 1 ns after a rising edge and samples at the following falling edge. Every value it observes is thus the result of exactly one edge. The same-cycle read rule is checked by sampling `cpu_rdata` in the cycle that carries both the read and the engine update, before that cycle's rising edge.

// File: rtl/ep0_stat_pkg.sv
package ep0_stat_pkg;
    localparam int REG_W  = 8;
    localparam int MODE_W = 4;

    typedef enum logic {WIN_IDLE, WIN_HOLD} win_state_e;
    typedef enum logic {LK_OPEN, LK_HELD}   lock_state_e;

    typedef struct packed {
        logic              setup;
        logic              in_rx;
        logic              out_rx;
        logic              acked;
        logic [MODE_W-1:0] mode;
    } ep0_mode_t;
endpackage

// File: rtl/ep0_setup_window.sv
module ep0_setup_window
    import ep0_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic setup_start,
    input  logic ctrl_wr_end,
    output logic win_active
);
    win_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WIN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_IDLE: if (setup_start) state_d = WIN_HOLD;
            WIN_HOLD: if (ctrl_wr_end && !setup_start) state_d = WIN_IDLE;
            default:  state_d = WIN_IDLE;
        endcase
    end

    always_comb begin
        win_active = (state_q == WIN_HOLD);
    end
endmodule

// File: rtl/ep0_lock_ctl.sv
module ep0_lock_ctl
    import ep0_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic eng_upd,
    input  logic cpu_rd_hit,
    output logic held
);
    lock_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN: if (eng_upd) state_d = LK_HELD;
            LK_HELD: if (cpu_rd_hit && !eng_upd) state_d = LK_OPEN;
            default: state_d = LK_OPEN;
        endcase
    end

    always_comb begin
        held = (state_q == LK_HELD);
    end
endmodule

// File: rtl/ep0_status_regs.sv
module ep0_status_regs
    import ep0_stat_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_addr,
    input  logic             cpu_wr,
    input  logic             cpu_rd,
    input  logic [7:0]       cpu_wdata,
    output logic [7:0]       cpu_rdata,
    input  logic             eng_setup_start,
    input  logic             eng_ctrl_wr_end,
    input  logic             eng_in_acked,
    input  logic             eng_out_acked,
    input  logic             eng_txn_acked,
    input  logic             eng_mode_load,
    input  logic [3:0]       eng_mode_val,
    input  logic             eng_cnt_load,
    input  logic [CNT_W-1:0] eng_cnt_val,
    output logic             fifo_wr_inhibit
);
    localparam int NREG     = 2;
    localparam int IDX_MODE = 0;
    localparam int IDX_CNT  = 1;

    logic [NREG-1:0] upd, rd_hit, wr_hit, held, wr_ok;
    logic            win_active;
    ep0_mode_t       mode_q, mode_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [REG_W-1:0] cnt_ext;

    assign upd[IDX_MODE] = eng_setup_start | eng_in_acked | eng_out_acked
                         | eng_txn_acked | eng_mode_load;
    assign upd[IDX_CNT]  = eng_cnt_load;

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_lock
            assign rd_hit[i] = cpu_rd && (cpu_addr == 1'(i));
            assign wr_hit[i] = cpu_wr && (cpu_addr == 1'(i));
            assign wr_ok[i]  = wr_hit[i] && !held[i] && !upd[i];
            ep0_lock_ctl u_lock (
                .clk        (clk),
                .rst_n      (rst_n),
                .eng_upd    (upd[i]),
                .cpu_rd_hit (rd_hit[i]),
                .held       (held[i])
            );
        end
    endgenerate

    ep0_setup_window u_win (
        .clk         (clk),
        .rst_n       (rst_n),
        .setup_start (eng_setup_start),
        .ctrl_wr_end (eng_ctrl_wr_end),
        .win_active  (win_active)
    );

    always_comb begin
        mode_d = mode_q;
        if (upd[IDX_MODE]) begin
            mode_d.setup  = mode_q.setup  | eng_setup_start;
            mode_d.in_rx  = mode_q.in_rx  | eng_in_acked;
            mode_d.out_rx = mode_q.out_rx | eng_out_acked;
            mode_d.acked  = mode_q.acked  | eng_txn_acked;
            if (eng_mode_load) mode_d.mode = eng_mode_val;
        end else if (wr_ok[IDX_MODE]) begin
            mode_d.setup  = 1'b0;
            mode_d.in_rx  = 1'b0;
            mode_d.out_rx = 1'b0;
            mode_d.acked  = 1'b0;
            mode_d.mode   = cpu_wdata[MODE_W-1:0];
        end
        if (win_active) mode_d.setup = 1'b1;
    end

    always_comb begin
        cnt_d = cnt_q;
        if (upd[IDX_CNT])          cnt_d = eng_cnt_val;
        else if (wr_ok[IDX_CNT])   cnt_d = cpu_wdata[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            cnt_q  <= '0;
        end else begin
            mode_q <= mode_d;
            cnt_q  <= cnt_d;
        end
    end

    always_comb begin
        cnt_ext = '0;
        cnt_ext[CNT_W-1:0] = cnt_q;
        cpu_rdata = cpu_addr ? cnt_ext : mode_q;
    end

    assign fifo_wr_inhibit = mode_q.setup;
endmodule

// File: rtl/ep0_status_regs_chk.sv
module ep0_status_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_addr,
    input logic       cpu_wr,
    input logic       cpu_rd,
    input logic [7:0] cpu_wdata,
    input logic       eng_setup_start,
    input logic       eng_in_acked,
    input logic       eng_out_acked,
    input logic       eng_txn_acked,
    input logic       eng_mode_load,
    input logic [7:0] mode_q,
    input logic       mode_locked,
    input logic       win_active,
    input logic       fifo_wr_inhibit
);
    logic eng_any;
    assign eng_any = eng_setup_start | eng_in_acked | eng_out_acked
                   | eng_txn_acked | eng_mode_load;

    a_r2_update_locks: assert property (@(posedge clk) disable iff (!rst_n)
        eng_any |=> mode_locked);

    a_r3_locked_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_locked && cpu_wr && !cpu_addr && !eng_any) |=> $stable(mode_q));

    a_r4_read_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_locked && cpu_rd && !cpu_addr && !eng_any) |=> !mode_locked);

    a_r5_write_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_locked && cpu_wr && !cpu_addr && !eng_any && !win_active)
        |=> (mode_q[7:4] == 4'h0 && mode_q[3:0] == $past(cpu_wdata[3:0])));

    a_r6_setup_pinned: assert property (@(posedge clk) disable iff (!rst_n)
        win_active |-> mode_q[7]);

    a_r7_in_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        eng_in_acked |=> mode_q[6]);

    a_r8_inhibit_on_setup: assert property (@(posedge clk) disable iff (!rst_n)
        eng_setup_start |=> fifo_wr_inhibit);
endmodule

bind ep0_status_regs ep0_status_regs_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cpu_addr        (cpu_addr),
    .cpu_wr          (cpu_wr),
    .cpu_rd          (cpu_rd),
    .cpu_wdata       (cpu_wdata),
    .eng_setup_start (eng_setup_start),
    .eng_in_acked    (eng_in_acked),
    .eng_out_acked   (eng_out_acked),
    .eng_txn_acked   (eng_txn_acked),
    .eng_mode_load   (eng_mode_load),
    .mode_q          (mode_q),
    .mode_locked     (held[0]),
    .win_active      (win_active),
    .fifo_wr_inhibit (fifo_wr_inhibit)
);

// File: tb/sim_ep0_status_regs.sv
`timescale 1ns/1ps
module sim_ep0_status_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_addr = 1'b0, cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       eng_setup_start = 1'b0, eng_ctrl_wr_end = 1'b0, eng_in_acked = 1'b0;
    logic       eng_out_acked = 1'b0, eng_txn_acked = 1'b0, eng_mode_load = 1'b0;
    logic [3:0] eng_mode_val = '0;
    logic       eng_cnt_load = 1'b0;
    logic [7:0] eng_cnt_val = '0;
    logic       fifo_wr_inhibit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural reference state
    int m_mode = 0, m_cnt = 0;
    bit m_lk_mode = 0, m_lk_cnt = 0, m_win = 0;

    always #2.5 clk = ~clk;

    ep0_status_regs #(.CNT_W(8)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .eng_setup_start(eng_setup_start), .eng_ctrl_wr_end(eng_ctrl_wr_end),
        .eng_in_acked(eng_in_acked), .eng_out_acked(eng_out_acked),
        .eng_txn_acked(eng_txn_acked), .eng_mode_load(eng_mode_load),
        .eng_mode_val(eng_mode_val), .eng_cnt_load(eng_cnt_load),
        .eng_cnt_val(eng_cnt_val), .fifo_wr_inhibit(fifo_wr_inhibit)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_lk_mode = 0; m_lk_cnt = 0; m_win = 0;
        end else begin
            bit ev_m;
            int nm;
            ev_m = eng_setup_start | eng_in_acked | eng_out_acked | eng_txn_acked | eng_mode_load;
            nm = m_mode;
            if (ev_m) begin
                if (eng_setup_start) nm = nm | 'h80;
                if (eng_in_acked)    nm = nm | 'h40;
                if (eng_out_acked)   nm = nm | 'h20;
                if (eng_txn_acked)   nm = nm | 'h10;
                if (eng_mode_load)   nm = (nm & 'hF0) | int'(eng_mode_val);
            end else if (cpu_wr && !cpu_addr && !m_lk_mode) begin
                nm = (m_win ? 'h80 : 0) | int'(cpu_wdata & 8'h0F);
            end
            if (m_win) nm = nm | 'h80;
            if (eng_cnt_load) m_cnt = int'(eng_cnt_val);
            else if (cpu_wr && cpu_addr && !m_lk_cnt) m_cnt = int'(cpu_wdata);
            m_mode = nm;
            if (ev_m) m_lk_mode = 1;
            else if (cpu_rd && !cpu_addr) m_lk_mode = 0;
            if (eng_cnt_load) m_lk_cnt = 1;
            else if (cpu_rd && cpu_addr) m_lk_cnt = 0;
            if (eng_setup_start) m_win = 1;
            else if (eng_ctrl_wr_end) m_win = 0;
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int exp_rd;
            exp_rd = cpu_addr ? m_cnt : m_mode;
            check(int'(cpu_rdata) == exp_rd, "R10 rdata vs model", int'(cpu_rdata), exp_rd);
            check(int'(fifo_wr_inhibit) == ((m_mode >> 7) & 1), "R8 inhibit vs model",
                  int'(fifo_wr_inhibit), (m_mode >> 7) & 1);
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
        cpu_wr = 0; cpu_rd = 0;
        eng_setup_start = 0; eng_ctrl_wr_end = 0; eng_in_acked = 0;
        eng_out_acked = 0; eng_txn_acked = 0; eng_mode_load = 0; eng_cnt_load = 0;
    endtask

    task automatic peek(input bit a, input int exp, input string req);
        cpu_addr = a;
        @(negedge clk);
        check(int'(cpu_rdata) == exp, req, int'(cpu_rdata), exp);
        cyc();
    endtask

    task automatic wr(input bit a, input logic [7:0] d);
        cpu_addr = a; cpu_wr = 1; cpu_wdata = d; cyc();
    endtask

    task automatic rd(input bit a);
        cpu_addr = a; cpu_rd = 1; cyc();
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        peek(0, 'h00, "R1 mode after reset");
        peek(1, 'h00, "R1 count after reset");
        check(fifo_wr_inhibit == 1'b0, "R1 inhibit after reset", int'(fifo_wr_inhibit), 0);

        // R5 unlocked write ignores upper data bits
        wr(0, 8'hF5);
        peek(0, 'h05, "R5 write clears flags, loads mode");

        // R2/R3 engine event locks, locked write dropped
        eng_in_acked = 1; cyc();
        peek(0, 'h45, "R7 in flag set");
        wr(0, 8'h00);
        peek(0, 'h45, "R3 locked write ignored");
        // R4 read releases lock
        rd(0);
        wr(0, 8'h0A);
        peek(0, 'h0A, "R4 write after read accepted");

        // R7 out/txn flags and mode load
        eng_out_acked = 1; eng_txn_acked = 1; cyc();
        peek(0, 'h3A, "R7 out and ack flags");
        eng_mode_load = 1; eng_mode_val = 4'h3; cyc();
        peek(0, 'h33, "R7 mode load keeps flags");
        rd(0);

        // R6 SETUP window
        eng_setup_start = 1; cyc();
        @(negedge clk);
        check(fifo_wr_inhibit == 1'b1, "R8 inhibit after setup", int'(fifo_wr_inhibit), 1);
        rd(0);
        wr(0, 8'h00);
        peek(0, 'h80, "R6 setup flag pinned in window");
        eng_ctrl_wr_end = 1; cyc();
        wr(0, 8'h00);
        peek(0, 'h00, "R6 setup flag clears after window");
        check(fifo_wr_inhibit == 1'b0, "R8 inhibit released", int'(fifo_wr_inhibit), 0);

        // R4 read in same cycle as update
        cpu_addr = 0; cpu_rd = 1; eng_mode_load = 1; eng_mode_val = 4'h7;
        @(negedge clk);
        check(cpu_rdata == 8'h00, "R4 same-cycle read gives old value", int'(cpu_rdata), 0);
        cyc();
        wr(0, 8'h01);
        peek(0, 'h07, "R4 same-cycle read keeps lock");

        // R3 engine wins over simultaneous CPU write
        rd(0);
        cpu_addr = 0; cpu_wr = 1; cpu_wdata = 8'h09; eng_mode_load = 1; eng_mode_val = 4'h2; cyc();
        peek(0, 'h02, "R3 engine priority over write");

        // R9 count register with independent lock
        rd(0);
        eng_cnt_load = 1; eng_cnt_val = 8'h5A; cyc();
        peek(1, 'h5A, "R9 count load");
        wr(1, 8'h11);
        peek(1, 'h5A, "R3 locked count write ignored");
        wr(0, 8'h04);
        peek(0, 'h04, "R2 mode lock independent of count lock");
        rd(1);
        wr(1, 8'h11);
        peek(1, 'h11, "R9 count write after read");

        // random traffic, compared each cycle by the model
        for (int i = 0; i < 2000; i++) begin
            int r;
            r = $urandom;
            cpu_addr = r[0]; cpu_wr = r[1]; cpu_rd = r[2] & r[3];
            cpu_wdata = 8'($urandom);
            eng_setup_start = (r[7:4] == 0);
            eng_ctrl_wr_end = (r[11:8] < 2);
            eng_in_acked = (r[14:12] == 0);
            eng_out_acked = (r[17:15] == 0);
            eng_txn_acked = (r[20:18] == 0);
            eng_mode_load = (r[23:21] == 0);
            eng_mode_val = r[27:24];
            eng_cnt_load = (r[30:28] == 0);
            eng_cnt_val = 8'($urandom);
            cyc();
        end

        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule